// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of an eight-line interrupt controller. Software reaches it through a byte-wide port with two addresses. Address bit 0 low selects the command port, and address bit 0 high selects the data (mask) port. The block steps through a four-word initialization sequence and then turns later writes into mode flags, mask register loads and one-cycle command pulses. A separate priority resolver owns the request and in-service registers and carries out those commands.

A command-port write with bit 4 set always restarts initialization. The next three data-port writes set the vector base, pass over the cascade word, and set the processor mode. Once the unit is ready, a command-port write with bit 4 clear is an operation command: with bit 3 set it is a mode/read-select command, and with bit 3 clear it is an end-of-interrupt or priority command. The block also steers the read data and gates the resolver's interrupt request with the ready flag.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset the unit waits for the first initialization word, ready is 0, and mask, vector base, every mode flag and every command pulse are 0.
- R2: A command-port write with bit 4 set drops ready and clears mask, poll arm, read-ISR select and special mask mode. In the following cycle it pulses init_clr for one cycle, which tells the resolver to clear requests and set lowest priority to line 7.
- R3: That first word is accepted only if bit 1 (single mode) is 0 and bit 0 (fourth word needed) is 1. Otherwise the unit keeps waiting for a first word, and data-port writes go on loading the mask.
- R4: After an accepted first word, the next data-port write sets vector base to the byte AND 0xF8. The data-port write after that is discarded, and leaves mask and vector base unchanged.
- R5: The next data-port write is the fourth word. With bit 0 at 0 it is rejected and the unit keeps waiting for a fourth word. With bit 0 at 1 it sets auto_eoi from bit 1, sets sfnm from bit 4 (only when IS_PRIMARY is 1; otherwise sfnm stays 0), and sets ready.
- R6: When no initialization is in progress, a data-port write loads the mask register with the byte.
- R7: When ready, a command-port write with bit 4 clear is decoded as a mode command if bit 3 is 1, and as an EOI/priority command if bit 3 is 0. When not ready, such writes have no effect.
- R8: An EOI/priority command sets rotate from bit 7. If bit 5 is set, it pulses eoi_valid in the next cycle with eoi_specific = bit 6 and eoi_level = bits 2:0. If bit 5 is clear and bits 6 and 7 are both set, it pulses prio_valid with prio_level = bits 2:0. In every other case neither pulse occurs.
- R9: A mode command writes smm from bit 5 only when bit 6 is set, writes read_isr from bit 0 only when bit 1 is set, and arms the poll when bit 2 is set.
- R10: A data-port read returns the mask. A command-port read returns poll_in when the poll is armed, otherwise isr_in if read_isr is set, otherwise irr_in. A command-port read while armed asserts poll_ack in that cycle and disarms the poll from the next cycle.
- R11: int_out follows req_in only while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | 0 = command port, 1 = data/mask port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |
| irr_in | input | 8 | Request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| poll_in | input | 8 | Poll answer byte from the resolver |
| req_in | input | 1 | Resolver's pending-interrupt request |
| poll_ack | output | 1 | Poll read taken this cycle |
| int_out | output | 1 | Gated interrupt request |
| ready | output | 1 | Initialization complete |
| mask | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| sfnm | output | 1 | Special fully nested mode |
| smm | output | 1 | Special mask mode |
| poll_armed | output | 1 | One-shot poll armed |
| read_isr | output | 1 | Command-port read selects in-service register |
| rotate | output | 1 | Rotate flag from last EOI/priority command |
| init_clr | output | 1 | One-cycle pulse after a first initialization word |
| eoi_valid | output | 1 | One-cycle EOI command pulse |
| eoi_specific | output | 1 | EOI names a specific line |
| eoi_level | output | 3 | Line named by the EOI |
| prio_valid | output | 1 | One-cycle set-priority pulse |
| prio_level | output | 3 | Line to become lowest priority |

## Verification
The bench builds two copies with LINES at its default of 8. One copy has IS_PRIMARY set to 1 and the other has it set to 0, and both receive the same stimulus. This exercises both variants of fourth-word handling: the fully nested bit is taken in one copy and forced to zero in the other. Directed sequences cover rejected first and fourth words, re-initialization while ready, and commands sent before ready. Random traffic then mixes restarts, mask loads, commands and reads in every initialization step.

// File: rtl/irq_seq_pkg.sv
// Shared types and byte field positions for the interrupt command sequencer.
// Assumes byte-wide command and data ports; bit positions are the wire format.
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_W1 = 2'd0,
        ST_W2 = 2'd1,
        ST_W3 = 2'd2,
        ST_W4 = 2'd3
    } init_step_e;

    // command-port type decode
    localparam int CMD_INIT_BIT = 4;
    localparam int CMD_MODE_BIT = 3;
    // first word
    localparam int W1_SINGLE_BIT = 1;
    localparam int W1_NEED4_BIT  = 0;
    // fourth word
    localparam int W4_CPU_BIT  = 0;
    localparam int W4_AEOI_BIT = 1;
    localparam int W4_SFNM_BIT = 4;
    // end-of-interrupt / priority command
    localparam int EC_ROT_BIT = 7;
    localparam int EC_SEL_BIT = 6;
    localparam int EC_EOI_BIT = 5;
    // mode command
    localparam int MC_SMM_EN_BIT  = 6;
    localparam int MC_SMM_BIT     = 5;
    localparam int MC_POLL_BIT    = 2;
    localparam int MC_RSEL_EN_BIT = 1;
    localparam int MC_RSEL_BIT    = 0;

    localparam logic [7:0] BASE_KEEP = 8'hF8;

endpackage

// File: rtl/irq_init_seq.sv
// Initialization word sequencer.
// Tracks which initialization word the data port expects, captures the vector
// base and processor-mode flags, and raises ready after a valid fourth word.
// Assumes cmd_init and data_wr are never high in the same cycle.
module irq_init_seq
    import irq_seq_pkg::*;
#(
    parameter int  LINES      = 8,
    parameter bit  IS_PRIMARY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_init,
    input  logic             data_wr,
    input  logic [LINES-1:0] wdata,
    output init_step_e       step,
    output logic             ready,
    output logic [LINES-1:0] vec_base,
    output logic             auto_eoi,
    output logic             sfnm,
    output logic             init_clr,
    output logic             mask_load
);

    logic first_ok;
    logic fourth_ok;

    // first word acceptable: multi-unit mode with a fourth word requested
    assign first_ok  = ~wdata[W1_SINGLE_BIT] & wdata[W1_NEED4_BIT];
    // fourth word acceptable: processor-mode bit set while expecting it
    assign fourth_ok = data_wr & (step == ST_W4) & wdata[W4_CPU_BIT];
    // data writes outside initialization go to the mask register
    assign mask_load = data_wr & (step == ST_W1);

    // step register, ready flag and one-cycle init pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= ST_W1;
            ready    <= 1'b0;
            init_clr <= 1'b0;
        end else begin
            init_clr <= cmd_init;
            if (cmd_init) begin
                ready <= 1'b0;
                step  <= first_ok ? ST_W2 : ST_W1;
            end else if (data_wr) begin
                unique case (step)
                    ST_W2:   step <= ST_W3;
                    ST_W3:   step <= ST_W4;
                    ST_W4: begin
                        if (fourth_ok) begin
                            step  <= ST_W1;
                            ready <= 1'b1;
                        end
                    end
                    default: step <= ST_W1;
                endcase
            end
        end
    end

    // vector base and auto-EOI capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base <= '0;
            auto_eoi <= 1'b0;
        end else begin
            if (data_wr && step == ST_W2 && !cmd_init)
                vec_base <= wdata & BASE_KEEP;
            if (fourth_ok && !cmd_init)
                auto_eoi <= wdata[W4_AEOI_BIT];
        end
    end

    // fully nested flag exists only on the primary unit
    generate
        if (IS_PRIMARY) begin : g_sfnm
            logic sfnm_q;
            // capture special fully nested mode from the fourth word
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sfnm_q <= 1'b0;
                else if (fourth_ok && !cmd_init)
                    sfnm_q <= wdata[W4_SFNM_BIT];
            end
            assign sfnm = sfnm_q;
        end else begin : g_no_sfnm
            assign sfnm = 1'b0;
        end
    endgenerate

    p_ready_from_w4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(data_wr && step == ST_W4 && wdata[W4_CPU_BIT]));

    p_base_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && step == ST_W2) |=> vec_base == ($past(wdata) & BASE_KEEP));

    p_first_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_init && (wdata[W1_SINGLE_BIT] || !wdata[W1_NEED4_BIT])) |=> step == ST_W1);

    p_w4_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && step == ST_W4 && !wdata[W4_CPU_BIT]) |=> (step == ST_W4 && !ready));

endmodule

// File: rtl/irq_op_decode.sv
// Operation command decoder.
// Holds the mask register and mode flags, and turns EOI/priority commands
// into one-cycle pulses for the resolver. Assumes init_now, mask_load and
// cmd_op are mutually exclusive in a cycle.
module irq_op_decode
    import irq_seq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic             init_now,
    input  logic             mask_load,
    input  logic             cmd_op,
    input  logic             poll_take,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] mask,
    output logic             smm,
    output logic             read_isr,
    output logic             poll_armed,
    output logic             rotate,
    output logic             eoi_valid,
    output logic             eoi_specific,
    output logic [$clog2(LINES)-1:0] eoi_level,
    output logic             prio_valid,
    output logic [$clog2(LINES)-1:0] prio_level
);

    localparam int LVL_W = $clog2(LINES);

    logic mode_cmd;
    logic ec_cmd;

    // command type, accepted only once the unit is ready
    assign mode_cmd = cmd_op & ready &  wdata[CMD_MODE_BIT];
    assign ec_cmd   = cmd_op & ready & ~wdata[CMD_MODE_BIT];

    // mask register and mode flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            smm      <= 1'b0;
            read_isr <= 1'b0;
        end else if (init_now) begin
            mask     <= '0;
            smm      <= 1'b0;
            read_isr <= 1'b0;
        end else begin
            if (mask_load)
                mask <= wdata;
            if (mode_cmd && wdata[MC_SMM_EN_BIT])
                smm <= wdata[MC_SMM_BIT];
            if (mode_cmd && wdata[MC_RSEL_EN_BIT])
                read_isr <= wdata[MC_RSEL_BIT];
        end
    end

    // one-shot poll arm, set by a mode command and spent by a poll read
    always_ff @(posedge clk) begin
        if (!rst_n)
            poll_armed <= 1'b0;
        else if (init_now)
            poll_armed <= 1'b0;
        else if (mode_cmd && wdata[MC_POLL_BIT])
            poll_armed <= 1'b1;
        else if (poll_take)
            poll_armed <= 1'b0;
    end

    // rotate flag and EOI / priority pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rotate       <= 1'b0;
            eoi_valid    <= 1'b0;
            eoi_specific <= 1'b0;
            eoi_level    <= '0;
            prio_valid   <= 1'b0;
            prio_level   <= '0;
        end else begin
            eoi_valid  <= 1'b0;
            prio_valid <= 1'b0;
            if (ec_cmd) begin
                rotate <= wdata[EC_ROT_BIT];
                if (wdata[EC_EOI_BIT]) begin
                    eoi_valid    <= 1'b1;
                    eoi_specific <= wdata[EC_SEL_BIT];
                    eoi_level    <= wdata[LVL_W-1:0];
                end else if (wdata[EC_SEL_BIT] && wdata[EC_ROT_BIT]) begin
                    prio_valid <= 1'b1;
                    prio_level <= wdata[LVL_W-1:0];
                end
            end
        end
    end

    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eoi_valid && prio_valid));

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_load |=> mask == $past(wdata));

    p_poll_oneshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_take && !cmd_op && !init_now) |=> !poll_armed);

    p_not_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op && !ready) |=> (!eoi_valid && !prio_valid));

    p_smm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op && wdata[CMD_MODE_BIT] && !wdata[MC_SMM_EN_BIT]) |=> $stable(smm));

endmodule

// File: rtl/irq_read_mux.sv
// Read data steering.
// Picks the byte returned on a read and flags a poll read. Purely
// combinational; assumes the resolver supplies poll_in for the current cycle.
module irq_read_mux #(
    parameter int LINES = 8
) (
    input  logic             rd_en,
    input  logic             addr,
    input  logic             poll_armed,
    input  logic             read_isr,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] irr_in,
    input  logic [LINES-1:0] isr_in,
    input  logic [LINES-1:0] poll_in,
    output logic [LINES-1:0] rdata,
    output logic             poll_take
);

    // a command-port read while armed answers the poll
    assign poll_take = rd_en & ~addr & poll_armed;

    // select the returned register
    always_comb begin
        if (addr)
            rdata = mask;
        else if (poll_armed)
            rdata = poll_in;
        else if (read_isr)
            rdata = isr_in;
        else
            rdata = irr_in;
    end

endmodule

// File: rtl/irq_cmd_seq.sv
// Interrupt controller command sequencer, top level.
// Splits port writes into initialization words, mask loads and operation
// commands, and gates the resolver's request with the ready flag.
// Assumes wr_en and rd_en are not both high in one cycle.
module irq_cmd_seq
    import irq_seq_pkg::*;
#(
    parameter int LINES      = 8,
    parameter bit IS_PRIMARY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    input  logic [LINES-1:0] irr_in,
    input  logic [LINES-1:0] isr_in,
    input  logic [LINES-1:0] poll_in,
    input  logic             req_in,
    output logic             poll_ack,
    output logic             int_out,
    output logic             ready,
    output logic [LINES-1:0] mask,
    output logic [LINES-1:0] vec_base,
    output logic             auto_eoi,
    output logic             sfnm,
    output logic             smm,
    output logic             poll_armed,
    output logic             read_isr,
    output logic             rotate,
    output logic             init_clr,
    output logic             eoi_valid,
    output logic             eoi_specific,
    output logic [$clog2(LINES)-1:0] eoi_level,
    output logic             prio_valid,
    output logic [$clog2(LINES)-1:0] prio_level
);

    logic       cmd_wr;
    logic       data_wr;
    logic       cmd_init;
    logic       cmd_op;
    logic       mask_load;
    logic       poll_take;
    init_step_e step;

    // port write classification
    assign cmd_wr   = wr_en & ~addr;
    assign data_wr  = wr_en &  addr;
    assign cmd_init = cmd_wr &  wdata[CMD_INIT_BIT];
    assign cmd_op   = cmd_wr & ~wdata[CMD_INIT_BIT];

    irq_init_seq #(.LINES(LINES), .IS_PRIMARY(IS_PRIMARY)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_init  (cmd_init),
        .data_wr   (data_wr),
        .wdata     (wdata),
        .step      (step),
        .ready     (ready),
        .vec_base  (vec_base),
        .auto_eoi  (auto_eoi),
        .sfnm      (sfnm),
        .init_clr  (init_clr),
        .mask_load (mask_load)
    );

    irq_op_decode #(.LINES(LINES)) u_op (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready        (ready),
        .init_now     (cmd_init),
        .mask_load    (mask_load),
        .cmd_op       (cmd_op),
        .poll_take    (poll_take),
        .wdata        (wdata),
        .mask         (mask),
        .smm          (smm),
        .read_isr     (read_isr),
        .poll_armed   (poll_armed),
        .rotate       (rotate),
        .eoi_valid    (eoi_valid),
        .eoi_specific (eoi_specific),
        .eoi_level    (eoi_level),
        .prio_valid   (prio_valid),
        .prio_level   (prio_level)
    );

    irq_read_mux #(.LINES(LINES)) u_rd (
        .rd_en      (rd_en),
        .addr       (addr),
        .poll_armed (poll_armed),
        .read_isr   (read_isr),
        .mask       (mask),
        .irr_in     (irr_in),
        .isr_in     (isr_in),
        .poll_in    (poll_in),
        .rdata      (rdata),
        .poll_take  (poll_take)
    );

    // no request leaves the unit before initialization completes
    assign int_out  = ready & req_in;
    assign poll_ack = poll_take;

    p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_init |=> (!ready && init_clr && mask == '0 && !poll_armed && !smm && !read_isr));

    p_step_idle_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> step == ST_W1);

endmodule

// File: tb/irq_cmd_seq_test.sv
`timescale 1ns/1ps
module irq_cmd_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, req_in = 1'b0;
    logic [7:0] wdata = '0, irr_in = '0, isr_in = '0, poll_in = '0;

    logic [7:0] rdata, mask, vec_base;
    logic       poll_ack, int_out, ready, auto_eoi, sfnm, smm, poll_armed;
    logic       read_isr, rotate, init_clr, eoi_valid, eoi_specific, prio_valid;
    logic [2:0] eoi_level, prio_level;

    logic [7:0] s_rdata, s_mask, s_vec_base;
    logic       s_poll_ack, s_int_out, s_ready, s_auto_eoi, s_sfnm, s_smm, s_poll_armed;
    logic       s_read_isr, s_rotate, s_init_clr, s_eoi_valid, s_eoi_specific, s_prio_valid;
    logic [2:0] s_eoi_level, s_prio_level;

    always #2 clk = ~clk;

    irq_cmd_seq #(.LINES(8), .IS_PRIMARY(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .poll_in(poll_in), .req_in(req_in), .poll_ack(poll_ack), .int_out(int_out),
        .ready(ready), .mask(mask), .vec_base(vec_base), .auto_eoi(auto_eoi),
        .sfnm(sfnm), .smm(smm), .poll_armed(poll_armed), .read_isr(read_isr),
        .rotate(rotate), .init_clr(init_clr), .eoi_valid(eoi_valid),
        .eoi_specific(eoi_specific), .eoi_level(eoi_level),
        .prio_valid(prio_valid), .prio_level(prio_level));

    irq_cmd_seq #(.LINES(8), .IS_PRIMARY(1'b0)) uut_sec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(s_rdata), .irr_in(irr_in), .isr_in(isr_in),
        .poll_in(poll_in), .req_in(req_in), .poll_ack(s_poll_ack), .int_out(s_int_out),
        .ready(s_ready), .mask(s_mask), .vec_base(s_vec_base), .auto_eoi(s_auto_eoi),
        .sfnm(s_sfnm), .smm(s_smm), .poll_armed(s_poll_armed), .read_isr(s_read_isr),
        .rotate(s_rotate), .init_clr(s_init_clr), .eoi_valid(s_eoi_valid),
        .eoi_specific(s_eoi_specific), .eoi_level(s_eoi_level),
        .prio_valid(s_prio_valid), .prio_level(s_prio_level));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int         m_step;
    bit         m_ready, m_aeoi, m_sfnm, m_smm, m_risr, m_poll, m_rot;
    logic [7:0] m_mask, m_base;
    bit         e_init, e_eoi, e_spec, e_prio;
    logic [2:0] e_eoi_lvl, e_prio_lvl;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_step = 0; m_ready = 0; m_aeoi = 0; m_sfnm = 0; m_smm = 0;
        m_risr = 0; m_poll = 0; m_rot = 0; m_mask = 0; m_base = 0;
        e_init = 0; e_eoi = 0; e_spec = 0; e_prio = 0; e_eoi_lvl = 0; e_prio_lvl = 0;
    endtask

    task automatic model_write(input bit a, input logic [7:0] d);
        e_init = 0; e_eoi = 0; e_prio = 0;
        if (a) begin
            case (m_step)
                1: begin m_base = d & 8'hF8; m_step = 2; end
                2: m_step = 3;
                3: if (d[0]) begin
                       m_aeoi = d[1]; m_sfnm = d[4]; m_ready = 1; m_step = 0;
                   end
                default: m_mask = d;
            endcase
        end else if (d[4]) begin
            m_ready = 0; m_mask = 0; m_poll = 0; m_risr = 0; m_smm = 0; e_init = 1;
            m_step = (!d[1] && d[0]) ? 1 : 0;
        end else if (m_ready) begin
            if (d[3]) begin
                if (d[6]) m_smm = d[5];
                if (d[1]) m_risr = d[0];
                if (d[2]) m_poll = 1;
            end else begin
                m_rot = d[7];
                if (d[5]) begin
                    e_eoi = 1; e_spec = d[6]; e_eoi_lvl = d[2:0];
                end else if (d[6] && d[7]) begin
                    e_prio = 1; e_prio_lvl = d[2:0];
                end
            end
        end
    endtask

    task automatic check_all();
        check("R6 mask", mask, m_mask);
        check("R4 vec_base", vec_base, m_base);
        check("R5 ready", ready, m_ready);
        check("R5 auto_eoi", auto_eoi, m_aeoi);
        check("R5 sfnm primary", sfnm, m_sfnm);
        check("R5 sfnm secondary", s_sfnm, 0);
        check("R5 ready secondary", s_ready, m_ready);
        check("R9 smm", smm, m_smm);
        check("R9 read_isr", read_isr, m_risr);
        check("R9 poll_armed", poll_armed, m_poll);
        check("R8 rotate", rotate, m_rot);
        check("R2 init_clr", init_clr, e_init);
        check("R8 eoi_valid", eoi_valid, e_eoi);
        check("R8 prio_valid", prio_valid, e_prio);
        if (e_eoi) begin
            check("R8 eoi_specific", eoi_specific, e_spec);
            check("R8 eoi_level", eoi_level, e_eoi_lvl);
        end
        if (e_prio) check("R8 prio_level", prio_level, e_prio_lvl);
        check("R11 int_out", int_out, m_ready & req_in);
    endtask

    task automatic do_write(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d; req_in = 1'($urandom);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
        model_write(a, d);
        #1;
        check_all();
    endtask

    task automatic do_read(input bit a);
        logic [7:0] exp;
        @(negedge clk);
        rd_en = 1; addr = a;
        irr_in = 8'($urandom); isr_in = 8'($urandom); poll_in = 8'($urandom);
        #1;
        if (a) exp = m_mask;
        else if (m_poll) exp = poll_in;
        else if (m_risr) exp = isr_in;
        else exp = irr_in;
        check("R10 rdata", rdata, exp);
        check("R10 poll_ack", poll_ack, (!a && m_poll) ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        rd_en = 0;
        if (!a) m_poll = 0;
        e_init = 0; e_eoi = 0; e_prio = 0;
        #1;
        check("R10 poll disarm", poll_armed, m_poll);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int r;
        r = $urandom(32'h1d3c);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 ready", ready, 0);
        check("R1 mask", mask, 0);
        check("R1 vec_base", vec_base, 0);
        check("R1 flags", {auto_eoi, sfnm, smm, poll_armed, read_isr, rotate}, 0);
        check("R1 pulses", {init_clr, eoi_valid, prio_valid}, 0);
        check("R11 int_out before ready", int_out, 0);

        do_write(1, 8'h5A);          // R6 mask before any init
        do_write(0, 8'h13);          // R3 single-mode set: rejected
        do_write(1, 8'h33);          // R3 still loads mask
        do_write(0, 8'h10);          // R3 no fourth word: rejected
        do_write(1, 8'h44);
        do_write(0, 8'h11);          // accepted first word
        do_write(1, 8'h2F);          // R4 base 0x28
        do_write(1, 8'hFF);          // R4 third word discarded
        do_write(1, 8'h12);          // R5 cpu bit clear: rejected
        do_write(1, 8'h13);          // R5 accepted, aeoi=1, sfnm=1
        do_write(1, 8'hA5);          // R6
        do_read(1);
        do_write(0, 8'h0B);          // R9 read ISR
        do_read(0);
        do_write(0, 8'h0C);          // R9 poll
        do_read(0);                  // R10 poll answered
        do_read(0);                  // R10 plain read after poll
        do_write(0, 8'h68);          // R9 smm on
        do_write(0, 8'h28);          // R9 smm bit without enable
        do_write(0, 8'h20);          // R8 non-specific EOI
        do_write(0, 8'h63);          // R8 specific EOI line 3
        do_write(0, 8'hC5);          // R8 priority line 5
        do_write(0, 8'h40);          // R8 select without rotate: nothing
        do_write(0, 8'hA0);          // R8 rotate EOI
        do_write(0, 8'h11);          // R2 re-init while ready
        do_write(0, 8'h20);          // R7 ignored before ready
        do_write(0, 8'h0C);          // R7 ignored before ready

        for (int i = 0; i < 1500; i++) begin
            r = int'($urandom % 100);
            d = 8'($urandom);
            if (r < 8) begin
                d[4] = 1'b1;
                if ($urandom % 10 < 7) begin d[1] = 1'b0; d[0] = 1'b1; end
                do_write(0, d);
            end else if (r < 45) begin
                do_write(1, d);
            end else if (r < 75) begin
                d[4] = 1'b0;
                do_write(0, d);
            end else begin
                do_read(1'($urandom));
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule